// File: doc/BRIEF.md
# Clock Page Replacement Engine

This block picks which page frame to evict from a small table of frames. Each frame has two bits: a resident flag and a reference flag. A hit port marks frames as recently used. When a fault request arrives, an empty frame is used if one exists. Otherwise the engine runs a second-chance sweep. A circular hand walks the frames in the order they were loaded. Any frame with its reference flag set gets the flag cleared and is passed over. The first frame found with a clear flag becomes the victim.

The victim index is returned on a valid/ready channel, and the engine holds it there until the consumer accepts it. When the victim is accepted, the engine marks that frame as resident and referenced, since it now holds the newly loaded page. The hand then moves to the frame after the victim.

An optional leading hand, turned on with `lead_en`, clears reference flags a fixed distance ahead of the evicting hand. This shortens the sweeps that follow. The fault request channel is also valid/ready. `req_ready` is high only while the engine is idle, and it stays low from the moment a request is accepted until the victim is accepted. The hit port has no ready signal and takes one hit every cycle.

Top module: `clock_evict_engine`

## Requirements
- R1: After reset, every frame is empty and has its reference flag clear, the hand is at frame 0, `req_ready` is 1 and `vic_valid` is 0.
- R2: If any frame is empty when a request is accepted, the lowest-numbered empty frame is reported, with `vic_valid` high in the very next cycle and no sweep.
- R3: The sweep tests one frame per cycle, starting at the hand. A frame with its reference flag at 1 has the flag cleared, and the hand advances by one, wrapping from NFRAMES-1 to 0.
- R4: The first frame tested with its reference flag at 0 is the victim. If t frames were passed over, `vic_valid` first goes high t+2 cycles after the request is accepted.
- R5: If every frame is resident with its reference flag set, the sweep makes one full revolution. The victim is then the frame the hand started at, reported NFRAMES+2 cycles after the request is accepted.
- R6: A hit (`hit_valid` high) sets the reference flag of frame `hit_idx` at the next clock edge, whatever state the engine is in.
- R7: If a hit and a sweep clear (from either hand) target the same frame in the same cycle, the hit wins and the flag ends at 1.
- R8: While `vic_valid` is high and `vic_ready` is low, `vic_valid` stays high and `vic_idx` does not change. `req_ready` stays 0 from the accepting edge until the victim is accepted.
- R9: When the victim is accepted, that frame becomes resident with its reference flag set, the hand moves to the frame after the victim (modulo NFRAMES), and in the next cycle `req_ready` is 1 and `vic_valid` is 0.
- R10: When `lead_en` is 1, every sweep cycle also clears the reference flag of the frame LEAD_DIST positions ahead of the hand (modulo NFRAMES). This includes the cycle in which the victim is found.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lead_en | input | 1 | Enables the leading clearing hand |
| hit_valid | input | 1 | Access to a frame this cycle |
| hit_idx | input | $clog2(NFRAMES) | Frame that was accessed |
| req_valid | input | 1 | Fault request |
| req_ready | output | 1 | Engine idle and able to take a request |
| vic_valid | output | 1 | Victim index available |
| vic_ready | input | 1 | Consumer accepts the victim |
| vic_idx | output | $clog2(NFRAMES) | Chosen victim frame |

## Verification
The table is first filled from empty, which exercises the free-frame path and its one-cycle latency. Next comes a fault with every flag set, which forces a full revolution and separates the hand's wrap from its start position.

After that, a long run of arithmetic hit patterns alternates with faults, and the leading hand is switched on and off in blocks of eight faults. In every case the bench compares both the victim index and the exact latency against a bench-side model of the policy. A wrong start point, a wrong clear order or a wrong lead offset shows up as either a different victim or a different cycle count.

Two directed cases complete the set. In the first, a hit lands on the frame under test in the first sweep cycle; if a clear is wrongly allowed to override that hit, the victim moves by one frame. In the second, the victim is held back under back-pressure for up to two cycles, to check that it stays stable.

// File: rtl/clock_evict_pkg.sv
package clock_evict_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SWEEP = 2'd1,
    ST_GRANT = 2'd2
  } sweep_state_e;
endpackage

// File: rtl/cev_first_free.sv
module cev_first_free #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  valid_vec,
  output logic          any_free,
  output logic [IW-1:0] free_idx
);
  // lowest-numbered empty frame wins
  always_comb begin
    any_free = 1'b0;
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid_vec[i]) begin
        any_free = 1'b1;
        free_idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/cev_frame_store.sv
module cev_frame_store #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hit_en,
  input  logic [IW-1:0] hit_idx,
  input  logic          clr_en,
  input  logic [IW-1:0] clr_idx,
  input  logic          lclr_en,
  input  logic [IW-1:0] lclr_idx,
  input  logic          fill_en,
  input  logic [IW-1:0] fill_idx,
  output logic [N-1:0]  valid_vec,
  output logic [N-1:0]  ref_vec
);
  for (genvar g = 0; g < N; g++) begin : g_frame
    logic res_q, use_q;
    logic set_use, drop_use;

    assign set_use  = (hit_en && hit_idx == IW'(g)) || (fill_en && fill_idx == IW'(g));
    assign drop_use = (clr_en && clr_idx == IW'(g)) || (lclr_en && lclr_idx == IW'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        res_q <= 1'b0;
        use_q <= 1'b0;
      end else begin
        if (fill_en && fill_idx == IW'(g)) res_q <= 1'b1;
        // setting has priority over any clearing hand
        if (set_use)       use_q <= 1'b1;
        else if (drop_use) use_q <= 1'b0;
      end
    end

    assign valid_vec[g] = res_q;
    assign ref_vec[g]   = use_q;
  end
endmodule

// File: rtl/cev_sweep_ctrl.sv
module cev_sweep_ctrl
  import clock_evict_pkg::*;
#(
  parameter int N  = 8,
  parameter int D  = 2,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lead_en,
  input  logic          req_valid,
  output logic          req_ready,
  output logic          vic_valid,
  input  logic          vic_ready,
  output logic [IW-1:0] vic_idx,
  input  logic          any_free,
  input  logic [IW-1:0] free_idx,
  input  logic [N-1:0]  ref_vec,
  output logic          clr_en,
  output logic [IW-1:0] clr_idx,
  output logic          lclr_en,
  output logic [IW-1:0] lclr_idx,
  output logic          fill_en,
  output logic [IW-1:0] fill_idx
);
  localparam logic [IW:0] NW    = (IW+1)'(N);
  localparam logic [IW:0] ONE_W = (IW+1)'(1);
  localparam logic [IW:0] LD_W  = (IW+1)'(D % N);

  sweep_state_e  state_q;
  logic [IW-1:0] hand_q, vic_q;

  function automatic logic [IW-1:0] ring_add(input logic [IW-1:0] p, input logic [IW:0] k);
    logic [IW:0] s;
    s = {1'b0, p} + k;
    if (s >= NW) s = s - NW;
    return s[IW-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      hand_q  <= '0;
      vic_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid) begin
          if (any_free) begin
            vic_q   <= free_idx;
            state_q <= ST_GRANT;
          end else begin
            state_q <= ST_SWEEP;
          end
        end
        ST_SWEEP: begin
          if (!ref_vec[hand_q]) begin
            vic_q   <= hand_q;
            state_q <= ST_GRANT;
          end else begin
            hand_q <= ring_add(hand_q, ONE_W);
          end
        end
        ST_GRANT: if (vic_ready) begin
          hand_q  <= ring_add(vic_q, ONE_W);
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign vic_valid = (state_q == ST_GRANT);
  assign vic_idx   = vic_q;
  assign clr_en    = (state_q == ST_SWEEP) && ref_vec[hand_q];
  assign clr_idx   = hand_q;
  assign lclr_en   = (state_q == ST_SWEEP) && lead_en;
  assign lclr_idx  = ring_add(hand_q, LD_W);
  assign fill_en   = vic_valid && vic_ready;
  assign fill_idx  = vic_q;
endmodule

// File: rtl/clock_evict_engine.sv
module clock_evict_engine #(
  parameter int NFRAMES   = 8,
  parameter int LEAD_DIST = 2,
  localparam int IDXW     = $clog2(NFRAMES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lead_en,
  input  logic            hit_valid,
  input  logic [IDXW-1:0] hit_idx,
  input  logic            req_valid,
  output logic            req_ready,
  output logic            vic_valid,
  input  logic            vic_ready,
  output logic [IDXW-1:0] vic_idx
);
  logic [NFRAMES-1:0] valid_vec, ref_vec;
  logic               any_free;
  logic [IDXW-1:0]    free_idx;
  logic               clr_en, lclr_en, fill_en;
  logic [IDXW-1:0]    clr_idx, lclr_idx, fill_idx;

  cev_first_free #(.N(NFRAMES), .IW(IDXW)) u_free (
    .valid_vec (valid_vec),
    .any_free  (any_free),
    .free_idx  (free_idx)
  );

  cev_frame_store #(.N(NFRAMES), .IW(IDXW)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .hit_en    (hit_valid),
    .hit_idx   (hit_idx),
    .clr_en    (clr_en),
    .clr_idx   (clr_idx),
    .lclr_en   (lclr_en),
    .lclr_idx  (lclr_idx),
    .fill_en   (fill_en),
    .fill_idx  (fill_idx),
    .valid_vec (valid_vec),
    .ref_vec   (ref_vec)
  );

  cev_sweep_ctrl #(.N(NFRAMES), .D(LEAD_DIST), .IW(IDXW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .lead_en   (lead_en),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .vic_valid (vic_valid),
    .vic_ready (vic_ready),
    .vic_idx   (vic_idx),
    .any_free  (any_free),
    .free_idx  (free_idx),
    .ref_vec   (ref_vec),
    .clr_en    (clr_en),
    .clr_idx   (clr_idx),
    .lclr_en   (lclr_en),
    .lclr_idx  (lclr_idx),
    .fill_en   (fill_en),
    .fill_idx  (fill_idx)
  );
endmodule

// File: rtl/clock_evict_checker.sv
module clock_evict_checker #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          hit_valid,
  input logic [IW-1:0] hit_idx,
  input logic          req_valid,
  input logic          req_ready,
  input logic          vic_valid,
  input logic          vic_ready,
  input logic [IW-1:0] vic_idx,
  input logic [N-1:0]  valid_vec,
  input logic [N-1:0]  ref_vec
);
  logic [N-1:0] ref_d;
  logic         full_d;

  always_ff @(posedge clk) begin
    ref_d  <= ref_vec;
    full_d <= &valid_vec;
  end

  assert_hit_sets_ref_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hit_valid |=> ref_vec[$past(hit_idx)]);

  assert_hit_beats_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_valid && !req_ready && !vic_valid) |=> ref_vec[$past(hit_idx)]);

  assert_free_fast_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !(&valid_vec)) |=> (vic_valid && !valid_vec[vic_idx]));

  assert_victim_unref_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(vic_valid) && full_d) |-> !ref_d[vic_idx]);

  assert_hold_victim_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (vic_valid && !vic_ready) |=> (vic_valid && $stable(vic_idx)));

  assert_busy_after_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  assert_fill_on_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (vic_valid && vic_ready) |=> (valid_vec[$past(vic_idx)] && ref_vec[$past(vic_idx)] && req_ready));
endmodule

bind clock_evict_engine clock_evict_checker #(.N(NFRAMES), .IW(IDXW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .hit_valid (hit_valid),
  .hit_idx   (hit_idx),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .vic_valid (vic_valid),
  .vic_ready (vic_ready),
  .vic_idx   (vic_idx),
  .valid_vec (valid_vec),
  .ref_vec   (ref_vec)
);

// File: tb/test_clock_evict_engine.sv
module test_clock_evict_engine;
  localparam int N  = 8;
  localparam int D  = 2;
  localparam int IW = $clog2(N);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lead_en = 1'b0;
  logic hit_valid = 1'b0;
  logic [IW-1:0] hit_idx = '0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic vic_valid;
  logic vic_ready = 1'b0;
  logic [IW-1:0] vic_idx;

  always #10 clk = ~clk;

  clock_evict_engine #(.NFRAMES(N), .LEAD_DIST(D)) i_clock_evict_engine (
    .clk(clk), .rst_n(rst_n), .lead_en(lead_en),
    .hit_valid(hit_valid), .hit_idx(hit_idx),
    .req_valid(req_valid), .req_ready(req_ready),
    .vic_valid(vic_valid), .vic_ready(vic_ready), .vic_idx(vic_idx)
  );

  int vectors = 0;
  int miscompares = 0;
  bit m_valid [N];
  bit m_ref [N];
  int m_hand = 0;

  task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic apply_hit(input int f);
    hit_valid = 1'b1;
    hit_idx = IW'(f);
    step();
    hit_valid = 1'b0;
    m_ref[f] = 1'b1;
  endtask

  task automatic run_fault(input string tag, input bit inject, input int hold);
    int free_f, h, exp_v, exp_lat, tests, c, start;
    free_f = -1;
    start = m_hand;
    for (int i = N - 1; i >= 0; i--) if (!m_valid[i]) free_f = i;
    if (free_f >= 0) begin
      exp_v = free_f;
      exp_lat = 1;
    end else begin
      h = m_hand;
      tests = 0;
      exp_v = 0;
      for (int k = 0; k < 3 * N; k++) begin
        int hv, lp;
        bit r;
        tests++;
        hv = (tests == 1 && inject) ? h : -1;
        lp = (h + D) % N;
        r = m_ref[h];
        if (r && h != hv) m_ref[h] = 1'b0;
        if (lead_en && lp != hv) m_ref[lp] = 1'b0;
        if (hv >= 0) m_ref[hv] = 1'b1;
        if (!r) begin
          exp_v = h;
          break;
        end
        h = (h + 1) % N;
      end
      exp_lat = tests + 1;
    end

    check(req_ready == 1'b1, tag, "req_ready before request", int'(req_ready), 1);
    req_valid = 1'b1;
    step();
    req_valid = 1'b0;
    c = 1;
    if (inject) begin
      hit_valid = 1'b1;
      hit_idx = IW'(start);
    end
    while (!vic_valid && c < 40) begin
      step();
      hit_valid = 1'b0;
      c++;
    end
    hit_valid = 1'b0;
    check(c == exp_lat, {tag, "/R3"}, "victim latency", c, exp_lat);
    check(int'(vic_idx) == exp_v, tag, "victim index", int'(vic_idx), exp_v);

    for (int k = 0; k < hold; k++) begin
      step();
      check(vic_valid && !req_ready && int'(vic_idx) == exp_v, "R8",
            "held victim", int'(vic_idx), exp_v);
    end
    vic_ready = 1'b1;
    step();
    vic_ready = 1'b0;
    check(req_ready && !vic_valid, "R9", "idle after accept",
          int'({req_ready, vic_valid}), 2);
    m_valid[exp_v] = 1'b1;
    m_ref[exp_v] = 1'b1;
    m_hand = (exp_v + 1) % N;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: run did not end, got 0 expected 1");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      m_valid[i] = 1'b0;
      m_ref[i] = 1'b0;
    end
    repeat (3) step();
    rst_n = 1'b1;
    step();
    check(req_ready == 1'b1, "R1", "req_ready after reset", int'(req_ready), 1);
    check(vic_valid == 1'b0, "R1", "vic_valid after reset", int'(vic_valid), 0);

    // Fill the empty table: frames come out in index order, one cycle each
    run_fault("R1", 1'b0, 0);
    for (int i = 1; i < N; i++) run_fault("R2", 1'b0, i % 3);

    // All flags set: full revolution back to frame 0
    run_fault("R5", 1'b0, 0);

    // Arithmetic hit patterns, leading hand toggled in blocks of eight
    for (int it = 0; it < 80; it++) begin
      lead_en = ((it / 8) % 2) == 1;
      if (it % 10 == 9) begin
        for (int f = 0; f < N; f++) apply_hit(f);
        run_fault("R6", 1'b0, it % 2);
      end else begin
        for (int f = 0; f < N; f++)
          if (((it * 5 + f * 3) % 7) < (it % 4)) apply_hit(f);
        if (lead_en) run_fault("R10", 1'b0, it % 2);
        else         run_fault("R4", 1'b0, it % 2);
      end
    end

    // Hit on the tested frame in the first sweep cycle must survive the clear
    lead_en = 1'b0;
    for (int f = 0; f < N; f++) apply_hit(f);
    run_fault("R7", 1'b1, 0);

    // Leading hand with every flag set ends the sweep early
    lead_en = 1'b1;
    for (int f = 0; f < N; f++) apply_hit(f);
    run_fault("R10", 1'b0, 2);
    lead_en = 1'b0;

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule